// File: doc/BRIEF.md
# Framed Serial Port with Selectable Frame-Sync Timing

This block is a synchronous serial port with one outgoing and one incoming data lane. Both lanes share a serial clock that also clocks the block. A frame-sync line marks where each word begins. Software-side logic writes parallel words into a single holding register. The port shifts each word out most significant bit first, changing the output on the rising serial clock edge. The incoming lane is sampled on the falling edge, and every complete word is presented in parallel together with a one-cycle valid strobe.

Two static configuration inputs set the protocol:

- **Sync timing.** The sync either comes one bit period ahead of the first data bit (early) or lands on the first data bit itself (late).
- **Framing.** In framed mode every word needs its own sync. In unframed mode words follow one another with no gap once the first sync has been seen.

The sync may arrive on an input pin or be produced inside the block. When produced inside, it is raised whenever a written word is waiting.

Once a word is under way, further syncs have no effect until its last bit has gone by. In early timing, a sync seen during the last bit starts the next word with no idle cycle between the two.

Top module: `fsync_sport`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle. After that edge `sdo`=0, `fs_out`=0, `rx_valid`=0, `tx_underflow`=0, `rx_overflow`=0 and `tx_empty`=1.
- R2: Each word is WORD_W bits long and is shifted out on `sdo` most significant bit first. Received bits are assembled so that the first bit received lands in bit WORD_W-1 of `rx_data`.
- R3: Early timing (`cfg_late`=0): a sync seen in serial cycle k puts the word's MSB on `sdo` in cycle k+1, and the receiver samples its first bit in cycle k+1.
- R4: Late timing (`cfg_late`=1): the MSB is on `sdo` in the same cycle as the sync, and the receiver samples its first bit in that cycle.
- R5: A sync that arrives while a word is in progress, before its last bit, has no effect. It neither restarts nor extends the word.
- R6: Early timing: a sync seen during the last bit of a word starts the next word in the following cycle, with no idle cycle in between.
- R7: When `cfg_fs_int`=1, `fs_out` is high for exactly one cycle per word. In early timing that cycle is the one before the first bit; in late timing it is the first bit cycle.
- R8: In framed mode (`cfg_unframed`=0) a word starts only on a sync, and with no sync `sdo` stays 0 after a word ends. In unframed mode, after the first sync, each word is followed at once by the next word with no sync.
- R9: If a word starts while the holding register is empty, zeros are sent and `tx_underflow` is set. The flag stays set until reset.
- R10: A received word appears on `rx_data` with `rx_valid` high for one cycle. This happens in the cycle after its last bit.
- R11: If a new word completes while the previous one is unread (no `rx_rd` since it arrived), `rx_overflow` is set until reset and the new word replaces the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; data launched on rising edge, sampled on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_late | input | 1 | 0: sync one bit ahead of data, 1: sync on first data bit |
| cfg_unframed | input | 1 | 1: continuous words after the first sync |
| cfg_fs_int | input | 1 | 1: sync generated inside the block, 0: taken from `fs_in` |
| fs_in | input | 1 | External frame sync |
| fs_out | output | 1 | Internally generated frame sync (0 when external) |
| sdo | output | 1 | Serial transmit data |
| sdi | input | 1 | Serial receive data |
| tx_wr | input | 1 | Write `tx_data` into the holding register |
| tx_data | input | WORD_W | Parallel transmit word |
| tx_empty | output | 1 | Holding register is empty |
| rx_data | output | WORD_W | Last completed received word |
| rx_valid | output | 1 | One-cycle strobe for a new received word |
| rx_rd | input | 1 | Marks the current received word as read |
| tx_underflow | output | 1 | Sticky: a word started with nothing to send |
| rx_overflow | output | 1 | Sticky: an unread received word was overwritten |

## Verification
The bench samples two nanoseconds after each rising edge. Cycle 0 is the cycle in which the word is written. With an external sync driven in cycle 1, the MSB is due in cycle 2 for early timing and in cycle 1 for late timing. `rx_valid` rises exactly WORD_W cycles after the first bit and must be low again one cycle later. Internally made syncs are checked in cycles 1 and 2. In back-to-back traffic, the second word's MSB is checked in the cycle right after the first word's LSB, and `rx_overflow` and `tx_underflow` are checked in the cycle where the second received word lands. Every comparison is tied to one of these fixed offsets, so a one-cycle slip in either direction shows up as a mismatch.

// File: rtl/fsp_pkg.sv
// Package: shared types for the framed serial port.
// Assumes nothing beyond IEEE 1800-2017.
package fsp_pkg;
    typedef enum logic {
        SYNC_EARLY = 1'b0,
        SYNC_LATE  = 1'b1
    } sync_mode_e;
endpackage

// File: rtl/fsp_tx.sv
// Transmit sequencer: holding register, shift register, bit counter and
// internal frame-sync generator. It also owns the falling-edge sampler of
// the effective frame sync. Assumes configuration is static outside reset
// and WORD_W is in 3..32.
module fsp_tx
    import fsp_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sync_mode_e        mode,
    input  logic              unframed,
    input  logic              fs_int_en,
    input  logic              fs_eff,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic              sdo,
    output logic              fs_gen,
    output logic              slot_act,
    output logic              hold_empty,
    output logic              underflow
);
    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
    localparam logic [CW-1:0] CNT_LATE = CW'(WORD_W - 1);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);

    logic [WORD_W-1:0] hold_q, sr_q, sr_n, word;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic              hold_full_q, hold_full_n;
    logic              active_q, active_n;
    logic              run_q, run_n;
    logic              fs_seen_q, fs_gen_n, uflow_q;
    logic              early, free, cont, start_full, start_late, start;

    // Sample the effective frame sync on the falling serial edge.
    always_ff @(negedge clk) begin
        if (!rst_n) fs_seen_q <= 1'b0;
        else        fs_seen_q <= fs_eff;
    end

    // Decide word starts and the next shifter state for the coming cycle.
    always_comb begin
        early      = (mode == SYNC_EARLY);
        free       = !active_q || (cnt_q == CNT_ONE);
        cont       = unframed && run_q && active_q && (cnt_q == CNT_ONE);
        start_full = cont || (early && free && fs_seen_q);
        start_late = !early && !active_q && fs_seen_q;
        start      = start_full || start_late;
        word       = hold_full_q ? hold_q : '0;
        active_n   = active_q;
        cnt_n      = cnt_q;
        sr_n       = sr_q;
        if (start_full) begin
            active_n = 1'b1;
            cnt_n    = CNT_FULL;
            sr_n     = word;
        end else if (start_late) begin
            active_n = 1'b1;
            cnt_n    = CNT_LATE;
            sr_n     = word << 1;
        end else if (active_q) begin
            sr_n = sr_q << 1;
            if (cnt_q == CNT_ONE) begin
                active_n = 1'b0;
                cnt_n    = '0;
            end else begin
                cnt_n = cnt_q - CNT_ONE;
            end
        end
        hold_full_n = wr ? 1'b1 : (start ? 1'b0 : hold_full_q);
        run_n       = run_q || start;
        fs_gen_n    = fs_int_en && hold_full_n && !(unframed && run_n) &&
                      (early ? (!active_n || cnt_n == CNT_ONE) : !active_n);
    end

    // Register shifter, counter, holding register, sync and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            sr_q        <= '0;
            cnt_q       <= '0;
            active_q    <= 1'b0;
            run_q       <= 1'b0;
            fs_gen      <= 1'b0;
            uflow_q     <= 1'b0;
        end else begin
            if (wr) hold_q <= wdata;
            hold_full_q <= hold_full_n;
            sr_q        <= sr_n;
            cnt_q       <= cnt_n;
            active_q    <= active_n;
            run_q       <= run_n;
            fs_gen      <= fs_gen_n;
            if (start && !hold_full_q) uflow_q <= 1'b1;
        end
    end

    // Drive the lane: shifter MSB in a word; pending MSB while idle in late mode.
    assign sdo = active_q ? sr_q[WORD_W-1]
                          : ((!early && hold_full_q) ? hold_q[WORD_W-1] : 1'b0);
    assign slot_act   = active_q;
    assign hold_empty = !hold_full_q;
    assign underflow  = uflow_q;

    AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        uflow_q |=> uflow_q); // R9
    AST_FS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fs_gen |=> !fs_gen); // R7
    AST_MIDWORD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && cnt_q > CNT_ONE) |=> (active_q && cnt_q == $past(cnt_q) - CNT_ONE)); // R5
endmodule

// File: rtl/fsp_rx.sv
// Receive assembler: samples the incoming lane on the falling edge during
// data slots, hands each complete word to the rising-edge side through a
// toggle, and keeps the valid strobe and sticky overflow flag.
// Assumes WORD_W is in 3..32.
module fsp_rx
    import fsp_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sync_mode_e        mode,
    input  logic              slot_act,
    input  logic              fs_eff,
    input  logic              sdi,
    input  logic              rd,
    output logic [WORD_W-1:0] data,
    output logic              valid,
    output logic              overflow
);
    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

    logic [WORD_W-2:0] sr_q;
    logic [WORD_W-1:0] done_q;
    logic [BW-1:0]     bits_q;
    logic              tgl_q, tgl_seen_q, avail_q, ovf_q, capture, newword;

    // A data slot, or the first bit of a late-sync word.
    assign capture = slot_act || ((mode == SYNC_LATE) && fs_eff);

    // Shift received bits in on the falling edge and close words.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            done_q <= '0;
            bits_q <= '0;
            tgl_q  <= 1'b0;
        end else if (capture) begin
            sr_q <= {sr_q[WORD_W-3:0], sdi};
            if (bits_q == BIT_LAST) begin
                bits_q <= '0;
                done_q <= {sr_q, sdi};
                tgl_q  <= ~tgl_q;
            end else begin
                bits_q <= bits_q + BW'(1);
            end
        end
    end

    assign newword = (tgl_q != tgl_seen_q);

    // Present completed words on the rising edge and track reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_seen_q <= 1'b0;
            data       <= '0;
            valid      <= 1'b0;
            avail_q    <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            tgl_seen_q <= tgl_q;
            valid      <= newword;
            if (newword) begin
                data    <= done_q;
                avail_q <= 1'b1;
                if (avail_q && !rd) ovf_q <= 1'b1;
            end else if (rd) begin
                avail_q <= 1'b0;
            end
        end
    end

    assign overflow = ovf_q;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q); // R11
endmodule

// File: rtl/fsync_sport.sv
// Top of the framed serial port. Selects the frame-sync source and wires
// the transmit sequencer to the receive assembler. The block is clocked by
// the serial clock. Configuration inputs are expected to change only
// while rst_n is low.
module fsync_sport
    import fsp_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_late,
    input  logic              cfg_unframed,
    input  logic              cfg_fs_int,
    input  logic              fs_in,
    output logic              fs_out,
    output logic              sdo,
    input  logic              sdi,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_empty,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_rd,
    output logic              tx_underflow,
    output logic              rx_overflow
);
    sync_mode_e mode;
    logic       fs_gen, fs_eff, slot_act;

    // Translate the timing select and pick the sync source.
    assign mode   = cfg_late ? SYNC_LATE : SYNC_EARLY;
    assign fs_eff = cfg_fs_int ? fs_gen : fs_in;
    assign fs_out = cfg_fs_int & fs_gen;

    fsp_tx #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .unframed   (cfg_unframed),
        .fs_int_en  (cfg_fs_int),
        .fs_eff     (fs_eff),
        .wr         (tx_wr),
        .wdata      (tx_data),
        .sdo        (sdo),
        .fs_gen     (fs_gen),
        .slot_act   (slot_act),
        .hold_empty (tx_empty),
        .underflow  (tx_underflow)
    );

    fsp_rx #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .slot_act (slot_act),
        .fs_eff   (fs_eff),
        .sdi      (sdi),
        .rd       (rx_rd),
        .data     (rx_data),
        .valid    (rx_valid),
        .overflow (rx_overflow)
    );
endmodule

// File: tb/fsync_sport_tb.sv
module fsync_sport_tb;
    localparam int W = 8;
    logic clk = 1'b0;
    logic rst_n = 1'b0, cfg_late = 1'b0, cfg_unframed = 1'b0, cfg_fs_int = 1'b0;
    logic fs_in = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic fs_out, sdo, tx_empty, rx_valid, tx_underflow, rx_overflow;
    logic [W-1:0] rx_data;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fsync_sport #(.WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_late(cfg_late), .cfg_unframed(cfg_unframed),
        .cfg_fs_int(cfg_fs_int), .fs_in(fs_in), .fs_out(fs_out), .sdo(sdo),
        .sdi(sdo), .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_rd(rx_rd),
        .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
    );

    // {late, word}: framed words with an external sync in cycle 1
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'hA5}, {1'b0, 8'h81}, {1'b0, 8'h3C},
        {1'b1, 8'hA5}, {1'b1, 8'h7E}, {1'b1, 8'h01}
    };

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic late, logic unf, logic fint);
        rst_n = 1'b0; cfg_late = late; cfg_unframed = unf; cfg_fs_int = fint;
        fs_in = 0; tx_wr = 0; rx_rd = 0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic write_word(logic [W-1:0] w);
        tx_wr = 1'b1; tx_data = w;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 0; step(); step();
        check("R1 sdo", sdo, 0); check("R1 fs_out", fs_out, 0);
        check("R1 rx_valid", rx_valid, 0); check("R1 flags", {tx_underflow, rx_overflow}, 0);
        check("R1 tx_empty", tx_empty, 1);

        // R2 R3 R4 R10: table walk, one framed word each
        for (int v = 0; v < 6; v++) begin
            logic lt;
            logic [W-1:0] w;
            lt = VEC[v][8]; w = VEC[v][7:0];
            do_reset(lt, 0, 0);
            write_word(w);
            step(); tx_wr = 0; fs_in = 1;
            if (!lt) begin step(); fs_in = 0; end
            for (int i = 0; i < W; i++) begin
                check(lt ? "R4 R2 bit" : "R3 R2 bit", sdo, w[W-1-i]);
                step(); fs_in = 0;
            end
            check("R10 valid", rx_valid, 1); check("R2 R10 rx_data", rx_data, w);
            step();
            check("R10 valid one cycle", rx_valid, 0);
        end

        // R6: early back-to-back with sync on the last bit
        do_reset(0, 0, 0);
        write_word(8'hC3); step(); tx_wr = 0; fs_in = 1; step(); fs_in = 0;
        for (int i = 0; i < W; i++) begin
            check("R6 w1 bit", sdo, 8'hC3 >> (W-1-i) & 1);
            if (i == 0) write_word(8'h5A);
            if (i == 1) tx_wr = 0;
            if (i == W-1) fs_in = 1;
            step();
        end
        fs_in = 0;
        check("R6 rx w1", rx_data, 8'hC3); rx_rd = 1;
        for (int i = 0; i < W; i++) begin
            check("R6 w2 no gap", sdo, 8'h5A >> (W-1-i) & 1);
            step(); rx_rd = 0;
        end
        check("R6 rx w2", {rx_valid, rx_data}, {1'b1, 8'h5A});
        check("R11 no overflow after read", rx_overflow, 0);

        // R5 R8: mid-word sync ignored, framed needs a new sync
        do_reset(0, 0, 0);
        write_word(8'hF0); step(); tx_wr = 0; fs_in = 1; step(); fs_in = 0;
        for (int i = 0; i < W; i++) begin
            if (i == 0) write_word(8'hFF);
            if (i == 1) tx_wr = 0;
            fs_in = (i == 3);
            step();
        end
        fs_in = 0;
        check("R5 word intact", rx_data, 8'hF0);
        check("R8 framed idle sdo", sdo, 0);
        check("R5 hold not consumed", tx_empty, 0);
        step(); step();
        check("R8 framed still idle", sdo, 0);

        // R8 R11 R9: unframed streaming, overflow and underflow
        do_reset(0, 1, 0);
        write_word(8'h96); step(); tx_wr = 0; fs_in = 1; step(); fs_in = 0;
        for (int i = 0; i < W; i++) begin
            if (i == 0) write_word(8'h69);
            if (i == 1) tx_wr = 0;
            step();
        end
        check("R8 unframed next MSB", sdo, 0);
        check("R8 unframed rx w1", rx_data, 8'h96);
        step();
        check("R8 unframed w2 bit1", sdo, 1);
        for (int i = 1; i < W; i++) step();
        check("R11 overflow set", rx_overflow, 1);
        check("R11 newest kept", rx_data, 8'h69);
        check("R9 unframed underflow", tx_underflow, 1);

        // R9: framed start with empty holding register
        do_reset(0, 0, 0);
        step(); fs_in = 1; step(); fs_in = 0;
        check("R9 zeros", sdo, 0); check("R9 flag", tx_underflow, 1);
        for (int i = 0; i < 10; i++) step();
        check("R9 sticky", tx_underflow, 1);

        // R7: internal sync, early
        do_reset(0, 0, 1);
        write_word(8'hB2); step(); tx_wr = 0;
        check("R7 early fs", fs_out, 1); check("R7 early sdo idle", sdo, 0);
        step();
        check("R7 early fs drop", fs_out, 0); check("R7 early MSB", sdo, 1);
        for (int i = 0; i < W; i++) step();
        check("R7 early rx", {rx_valid, rx_data}, {1'b1, 8'hB2});

        // R7: internal sync, late
        do_reset(1, 0, 1);
        write_word(8'h4D); step(); tx_wr = 0;
        check("R7 late fs", fs_out, 1); check("R7 late MSB", sdo, 0);
        step();
        check("R7 late fs drop", fs_out, 0); check("R7 late bit6", sdo, 1);
        for (int i = 1; i < W; i++) step();
        check("R7 late rx", {rx_valid, rx_data}, {1'b1, 8'h4D});

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule